// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block collects up to eight interrupt request lines, ranks them under a programmable rotating priority, and raises a single interrupt output toward a processor. Software reaches it over a byte-wide register bus with two addresses: a command address (address 0) for initialisation and operation commands, and a data address (address 1) for the initialisation bytes and the mask register. When the processor takes the interrupt it pulses the acknowledge input. In that same cycle the block presents the vector byte: the programmed vector base with its low three bits replaced by the winning level. It then moves that level from pending to in service.

The controller keeps three registers: pending requests, in-service levels and the mask. It also keeps a per-line trigger-mode register, which selects edge or level sensing and is written through its own strobe. Software can end a service by priority or by naming a level, rotate the priority order, turn on automatic end of service, and use a special masking mode that lets lower levels interrupt a masked service routine. It can also poll instead of acknowledging, and read back the pending or in-service register. Chaining a second controller is not provided. The cascade byte of the initialisation sequence is accepted and discarded.

Top module: `rpic_ctrl`

## Requirements
- R1: After reset, irq_out is 0, the pending, in-service and mask registers are 0, the lowest-priority level is 7, the controller counts as not initialised, and a command-address read returns the pending register (0).
- R2: A command write with bit 4 = 1 clears the pending, in-service and mask registers and the auto-end, rotate-on-auto-end, special-mask, poll and in-service-readback flags. It sets the lowest-priority level to 7 and waits for the vector base.
- R3: After that command, the first data write stores the vector base (bits 7:3 kept), the second is discarded, and in the third bit 1 = 1 enables automatic end of service. irq_out stays 0 until this third write.
- R4: The winner is the first set bit of (pending AND NOT mask) OR in-service, searched from the level after the lowest-priority level upward with wrap-around. irq_out is 1 when the block is initialised and the winner is a pending request that is not in service.
- R5: While special mask mode is on and the mask is non-zero, in-service bits take no part in the search. With a zero mask the mode has no effect.
- R6: While ack is high, ack_vector = {base[7:3], winning level}. On that edge, if irq_out is 1, the winner's pending bit is cleared and its in-service bit set. With nothing pending, ack_vector = {base[7:3], 3'd7} and no state changes.
- R7: With automatic end of service, an acknowledge leaves the in-service bit clear. When rotate-on-auto-end is also on (command code 4 in bits 7:5 sets it, code 0 clears it), the acknowledged level becomes the lowest priority.
- R8: A command write with bits 4:3 = 00 and bits 7:5 = 1 clears the highest-priority in-service bit. With bits 7:5 = 5 it also makes that level the lowest priority.
- R9: With bits 4:3 = 00 and the level in bits 2:0, code 3 clears that in-service bit. Code 6 sets the lowest-priority level, code 7 does both, and code 2 changes nothing.
- R10: A command write with bit 7 = 0 and bits 4:3 = 01 and bit 1 = 1 selects command-address readback: in-service register when bit 0 = 1, pending register when bit 0 = 0. Bit 6 = 1 loads special mask mode from bit 5.
- R11: Such a write with bit 2 = 1 arms a poll. Unless in-service readback is selected, the next command read returns 0x80 OR the winning level and acknowledges it as in R6, or returns 0 when nothing is pending. Either way the read disarms the poll.
- R12: A line whose trig_wdata bit is 1 (level mode) has its pending bit follow the line each cycle. A line whose bit is 0 (edge mode) latches a pending bit only on a 0-to-1 transition, and that bit stays until acknowledged or cleared by initialisation.
- R13: A data-address read returns the mask register. Data writes outside the initialisation steps load the mask, including before the first initialisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a poll read takes effect on the edge) |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| trig_wr | input | 1 | Write strobe for the trigger-mode register |
| trig_wdata | input | 8 | Trigger mode per line, 1 = level, 0 = edge |
| irq_lines | input | 8 | Interrupt request lines, active high |
| irq_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Interrupt acknowledge, one cycle per acknowledge |
| ack_vector | output | 8 | Vector byte, valid while ack is high |

## Verification
The priority search is exercised with one request alone and with two or three requests set together. Each pattern is run under the reset priority order, after an explicit priority change and after a rotation, so the vector shows whether the search start and the wrap-around are right. Nested cases put an in-service level ahead of a later request and then behind an earlier one, which separates blocking from pre-emption. The same patterns are repeated with special mask mode on and off and with a zero and a non-zero mask. Edge-mode and level-mode lines are each held high across an acknowledge, which shows whether a request re-arms from the line state or only on a new rising edge.

// File: rtl/rpic_pkg.sv
// Shared constants and types for the rotating-priority interrupt controller.
// Assumes a byte-wide register bus and eight request lines.
package rpic_pkg;

    localparam int LINES = 8;
    localparam int LVL_W = $clog2(LINES);
    localparam int BASE_W = 8 - LVL_W;

    // Initialisation progress; only ST_READY lets the output assert.
    typedef enum logic [2:0] {
        ST_RAW   = 3'd0,
        ST_BASE  = 3'd1,
        ST_CASC  = 3'd2,
        ST_MODE  = 3'd3,
        ST_READY = 3'd4
    } init_step_t;

    // Operation codes carried in bits 7:5 of an end-of-service command.
    typedef enum logic [2:0] {
        OP_ROT_AUTO_OFF = 3'd0,
        OP_EOI_PRIO     = 3'd1,
        OP_NOP          = 3'd2,
        OP_EOI_LEVEL    = 3'd3,
        OP_ROT_AUTO_ON  = 3'd4,
        OP_EOI_PRIO_ROT = 3'd5,
        OP_SET_LOWEST   = 3'd6,
        OP_EOI_LVL_ROT  = 3'd7
    } eoi_op_t;

endpackage

// File: rtl/rpic_prio_pick.sv
// Rotating first-set-bit search. Scans the candidate vector starting one
// position above low_idx, wrapping around, and reports the first hit.
// Purely combinational; assumes N is a power of two.
module rpic_prio_pick #(
    parameter int N = 8,
    localparam int LW = $clog2(N)
) (
    input  logic [N-1:0]  cand,
    input  logic [LW-1:0] low_idx,
    output logic          hit,
    output logic [LW-1:0] lvl
);

    // Walk the N positions in rotated order and keep the first set one.
    always_comb begin
        hit = 1'b0;
        lvl = '0;
        for (int k = 1; k <= N; k++) begin
            logic [LW-1:0] pos;
            pos = low_idx + LW'(k);
            if (!hit && cand[pos]) begin
                hit = 1'b1;
                lvl = pos;
            end
        end
    end

endmodule

// File: rtl/rpic_req_capture.sv
// Pending-request register. Each line is sensed either by level (bit
// follows the line) or by rising edge (bit latches until cleared).
// Assumes request lines are already synchronous to clk.
module rpic_req_capture #(
    parameter int N = 8,
    localparam int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  lines,
    input  logic [N-1:0]  level_sel,
    input  logic          clr_all,
    input  logic          clr_one,
    input  logic [LW-1:0] clr_lvl,
    output logic [N-1:0]  pend
);

    for (genvar g = 0; g < N; g++) begin : g_line
        logic prev_q;
        logic req_q;
        logic rise;

        assign rise = lines[g] & ~prev_q;

        // Remember the previous line state for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= lines[g];
        end

        // Update this line's pending bit by its selected trigger mode.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all)                   req_q <= 1'b0;
            else if (level_sel[g])                   req_q <= lines[g];
            else if (rise)                           req_q <= 1'b1;
            else if (clr_one && clr_lvl == LW'(g))   req_q <= 1'b0;
        end

        assign pend[g] = req_q;
    end

endmodule

// File: rtl/rpic_cmd_decode.sv
// Splits a command-address write byte into its command class and fields.
// Combinational; the caller qualifies the outputs with the write strobe.
module rpic_cmd_decode
    import rpic_pkg::*;
(
    input  logic [7:0]       wdata,
    output logic             is_init,
    output logic             is_eoi,
    output logic             is_opt,
    output eoi_op_t          op,
    output logic [LVL_W-1:0] lvl,
    output logic             smm_load,
    output logic             smm_val,
    output logic             poll_arm,
    output logic             rsel_load,
    output logic             rsel_isr
);

    // Classify by bits 7, 4 and 3 and pull out the operand fields.
    always_comb begin
        is_init   = wdata[4];
        is_eoi    = (wdata[4:3] == 2'b00);
        is_opt    = !wdata[7] && (wdata[4:3] == 2'b01);
        op        = eoi_op_t'(wdata[7:5]);
        lvl       = wdata[LVL_W-1:0];
        smm_load  = wdata[6];
        smm_val   = wdata[5];
        poll_arm  = wdata[2];
        rsel_load = wdata[1];
        rsel_isr  = wdata[0];
    end

endmodule

// File: rtl/rpic_ctrl.sv
// Eight-input rotating-priority interrupt controller, top level.
// Holds the initialisation sequencer, mode flags, mask and in-service
// registers; request capture and priority search live in submodules.
// Assumes software never issues a bus access in the same cycle as ack.
module rpic_ctrl
    import rpic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       trig_wr,
    input  logic [7:0] trig_wdata,
    input  logic [7:0] irq_lines,
    output logic       irq_out,
    input  logic       ack,
    output logic [7:0] ack_vector
);

    init_step_t        step_q;
    logic [BASE_W-1:0] base_q;
    logic              aeoi_q, rot_q, smm_q, poll_q, rdisr_q;
    logic [LVL_W-1:0]  low_q;
    logic [LINES-1:0]  imr_q, isr_q, trig_q;

    logic [LINES-1:0]  irr_w;
    logic [LINES-1:0]  svc_w, cand_w;
    logic              win_hit, eoi_hit, pending, ready, take;
    logic [LVL_W-1:0]  win_lvl, eoi_lvl;
    logic [LINES-1:0]  win_oh;

    logic              cmd_wr, data_wr, cmd_rd;
    logic              d_init, d_eoi, d_opt, d_smm_load, d_smm_val;
    logic              d_poll, d_rsel_load, d_rsel_isr;
    eoi_op_t           d_op;
    logic [LVL_W-1:0]  d_lvl;

    assign cmd_wr  = bus_wr && !bus_addr;
    assign data_wr = bus_wr && bus_addr;
    assign cmd_rd  = bus_rd && !bus_addr;
    assign ready   = (step_q == ST_READY);

    rpic_cmd_decode u_dec (
        .wdata     (bus_wdata),
        .is_init   (d_init),
        .is_eoi    (d_eoi),
        .is_opt    (d_opt),
        .op        (d_op),
        .lvl       (d_lvl),
        .smm_load  (d_smm_load),
        .smm_val   (d_smm_val),
        .poll_arm  (d_poll),
        .rsel_load (d_rsel_load),
        .rsel_isr  (d_rsel_isr)
    );

    // In-service bits that take part in the search (dropped in special mask mode).
    always_comb begin
        svc_w  = (smm_q && (imr_q != '0)) ? '0 : isr_q;
        cand_w = (irr_w & ~imr_q) | svc_w;
    end

    rpic_prio_pick #(.N(LINES)) u_win (
        .cand    (cand_w),
        .low_idx (low_q),
        .hit     (win_hit),
        .lvl     (win_lvl)
    );

    rpic_prio_pick #(.N(LINES)) u_eoi (
        .cand    (isr_q),
        .low_idx (low_q),
        .hit     (eoi_hit),
        .lvl     (eoi_lvl)
    );

    // A request wins only if the first candidate is not an in-service level.
    always_comb begin
        win_oh  = LINES'(1) << win_lvl;
        pending = ready && win_hit && ((win_oh & svc_w) == '0);
        take    = pending && (ack || (cmd_rd && !rdisr_q && poll_q));
    end

    assign irq_out    = pending;
    assign ack_vector = {base_q, pending ? win_lvl : LVL_W'(LINES - 1)};

    rpic_req_capture #(.N(LINES)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines     (irq_lines),
        .level_sel (trig_q),
        .clr_all   (cmd_wr && d_init),
        .clr_one   (take),
        .clr_lvl   (win_lvl),
        .pend      (irr_w)
    );

    // Read mux: mask on the data address, readback or poll result on command.
    always_comb begin
        if (bus_addr)     bus_rdata = imr_q;
        else if (rdisr_q) bus_rdata = isr_q;
        else if (poll_q)  bus_rdata = pending ? {1'b1, {(7 - LVL_W){1'b0}}, win_lvl} : 8'h00;
        else              bus_rdata = irr_w;
    end

    // Trigger-mode register, loaded only through its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       trig_q <= '0;
        else if (trig_wr) trig_q <= trig_wdata;
    end

    // Sequencer, mode flags, mask, in-service register and priority pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= ST_RAW;
            base_q  <= '0;
            aeoi_q  <= 1'b0;
            rot_q   <= 1'b0;
            smm_q   <= 1'b0;
            poll_q  <= 1'b0;
            rdisr_q <= 1'b0;
            low_q   <= LVL_W'(LINES - 1);
            imr_q   <= '0;
            isr_q   <= '0;
        end else begin
            if (take) begin
                if (!aeoi_q) isr_q <= isr_q | win_oh;
                else if (rot_q) low_q <= win_lvl;
            end else if (cmd_wr && d_init) begin
                isr_q   <= '0;
                imr_q   <= '0;
                aeoi_q  <= 1'b0;
                rot_q   <= 1'b0;
                smm_q   <= 1'b0;
                poll_q  <= 1'b0;
                rdisr_q <= 1'b0;
                low_q   <= LVL_W'(LINES - 1);
                step_q  <= ST_BASE;
            end else if (cmd_wr && d_eoi) begin
                case (d_op)
                    OP_ROT_AUTO_OFF: rot_q <= 1'b0;
                    OP_ROT_AUTO_ON:  rot_q <= 1'b1;
                    OP_EOI_PRIO: begin
                        if (eoi_hit) isr_q[eoi_lvl] <= 1'b0;
                    end
                    OP_EOI_PRIO_ROT: begin
                        if (eoi_hit) begin
                            isr_q[eoi_lvl] <= 1'b0;
                            low_q          <= eoi_lvl;
                        end
                    end
                    OP_EOI_LEVEL:    isr_q[d_lvl] <= 1'b0;
                    OP_SET_LOWEST:   low_q <= d_lvl;
                    OP_EOI_LVL_ROT: begin
                        isr_q[d_lvl] <= 1'b0;
                        low_q        <= d_lvl;
                    end
                    default: ;
                endcase
            end else if (cmd_wr && d_opt) begin
                if (d_smm_load)  smm_q   <= d_smm_val;
                if (d_poll)      poll_q  <= 1'b1;
                if (d_rsel_load) rdisr_q <= d_rsel_isr;
            end else if (data_wr) begin
                case (step_q)
                    ST_BASE: begin
                        base_q <= bus_wdata[7:LVL_W];
                        step_q <= ST_CASC;
                    end
                    ST_CASC: step_q <= ST_MODE;
                    ST_MODE: begin
                        aeoi_q <= bus_wdata[1];
                        step_q <= ST_READY;
                    end
                    default: imr_q <= bus_wdata;
                endcase
            end
            if (cmd_rd && !rdisr_q && poll_q) poll_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rpic_checker.sv
// Property checker for rpic_ctrl, attached by bind. Observes ports and the
// controller's internal registers; drives nothing.
module rpic_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_addr,
    input logic [7:0] bus_wdata,
    input logic       ack,
    input logic       irq_out,
    input logic [7:0] ack_vector,
    input logic       ready,
    input logic       aeoi,
    input logic [7:0] irr,
    input logic [7:0] imr,
    input logic [7:0] isr
);

    // R3: no interrupt before the initialisation sequence completes.
    a_r3_quiet_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !irq_out);

    // R4: a signalled winner is a pending, unmasked request.
    a_r4_winner_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (irr[ack_vector[2:0]] && !imr[ack_vector[2:0]]));

    // R6: acknowledge without auto-end marks the level in service.
    a_r6_ack_marks_service: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_out && !aeoi) |=> isr[$past(ack_vector[2:0])]);

    // R7: acknowledge with auto-end leaves the level out of service.
    a_r7_auto_end_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_out && aeoi) |=> !isr[$past(ack_vector[2:0])]);

    // R2: initialisation command empties every register.
    a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[4] && !ack)
        |=> (isr == 8'h00 && imr == 8'h00 && irr == 8'h00 && !ready));

    // R9: a specific end of service clears the named level.
    a_r9_specific_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[4:3] == 2'b00 && bus_wdata[6:5] == 2'b11 && !ack)
        |=> !isr[$past(bus_wdata[2:0])]);

endmodule

bind rpic_ctrl rpic_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .ack        (ack),
    .irq_out    (irq_out),
    .ack_vector (ack_vector),
    .ready      (ready),
    .aeoi       (aeoi_q),
    .irr        (irr_w),
    .imr        (imr_q),
    .isr        (isr_q)
);

// File: tb/tb_rpic_ctrl.sv
// Directed bench for rpic_ctrl: one task per scenario, each checking itself.
module tb_rpic_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       trig_wr = 1'b0;
    logic [7:0] trig_wdata = 8'h00;
    logic [7:0] irq_lines = 8'h00;
    logic       irq_out;
    logic       ack = 1'b0;
    logic [7:0] ack_vector;

    int checks = 0;
    int failures = 0;
    logic [7:0] v;

    always #10 clk = ~clk;

    rpic_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .trig_wr    (trig_wr),
        .trig_wdata (trig_wdata),
        .irq_lines  (irq_lines),
        .irq_out    (irq_out),
        .ack        (ack),
        .ack_vector (ack_vector)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic cmd_w(input logic [7:0] d);
        bus_write(1'b0, d);
    endtask

    task automatic dat_w(input logic [7:0] d);
        bus_write(1'b1, d);
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_ack(output logic [7:0] d);
        @(negedge clk);
        ack = 1'b1;
        #1 d = ack_vector;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic set_lines(input logic [7:0] l);
        @(negedge clk);
        irq_lines = l;
        @(negedge clk);
    endtask

    task automatic init_seq(input logic [7:0] base, input logic auto_end);
        cmd_w(8'h10);
        dat_w(base);
        dat_w(8'h00);
        dat_w(auto_end ? 8'h03 : 8'h01);
    endtask

    task automatic t_reset;
        chk("R1 irq_out after reset", {7'd0, irq_out}, 8'h00);
        bus_read(1'b0, v); chk("R1 pending after reset", v, 8'h00);
        bus_read(1'b1, v); chk("R13 mask after reset", v, 8'h00);
        dat_w(8'h5A);
        bus_read(1'b1, v); chk("R13 mask write before init", v, 8'h5A);
    endtask

    task automatic t_init;
        cmd_w(8'h10);
        bus_read(1'b1, v); chk("R2 mask cleared by init", v, 8'h00);
        dat_w(8'h40);
        dat_w(8'h04);
        set_lines(8'h08);
        chk("R3 quiet before last init byte", {7'd0, irq_out}, 8'h00);
        set_lines(8'h00);
        dat_w(8'h01);
        chk("R3 irq after last init byte", {7'd0, irq_out}, 8'h01);
        do_ack(v); chk("R6 vector base 40 level 3", v, 8'h43);
        cmd_w(8'h0B);
        bus_read(1'b0, v); chk("R10 in-service readback", v, 8'h08);
        cmd_w(8'h0A);
        bus_read(1'b0, v); chk("R6 pending cleared by ack", v, 8'h00);
        cmd_w(8'h20);
        cmd_w(8'h0B);
        bus_read(1'b0, v); chk("R8 priority end of service", v, 8'h00);
    endtask

    task automatic t_priority;
        init_seq(8'h20, 1'b0);
        bus_read(1'b0, v); chk("R2 readback select cleared", v, 8'h00);
        set_lines(8'h22);
        chk("R4 fixed order picks 1", ack_vector, 8'h21);
        cmd_w(8'hC2);
        chk("R9 lowest=2 picks 5", ack_vector, 8'h25);
        cmd_w(8'h40);
        chk("R9 no-op keeps order", ack_vector, 8'h25);
        cmd_w(8'hC7);
        dat_w(8'h02);
        chk("R4 mask hides level 1", ack_vector, 8'h25);
        bus_read(1'b1, v); chk("R13 mask readback", v, 8'h02);
        dat_w(8'h00);
        do_ack(v); chk("R6 ack level 1", v, 8'h21);
        chk("R4 in-service 1 blocks 5", {7'd0, irq_out}, 8'h00);
        set_lines(8'h23);
        chk("R4 level 0 pre-empts", {7'd0, irq_out}, 8'h01);
        do_ack(v); chk("R6 ack level 0", v, 8'h20);
        cmd_w(8'h0B);
        bus_read(1'b0, v); chk("R6 nested in-service", v, 8'h03);
        cmd_w(8'h20);
        bus_read(1'b0, v); chk("R8 clears highest in-service", v, 8'h02);
        cmd_w(8'h61);
        bus_read(1'b0, v); chk("R9 specific clear level 1", v, 8'h00);
        chk("R4 level 5 now wins", ack_vector, 8'h25);
        set_lines(8'h00);
    endtask

    task automatic t_smm;
        do_ack(v); chk("R6 ack level 5", v, 8'h25);
        set_lines(8'h40);
        chk("R5 in-service 5 blocks 6", {7'd0, irq_out}, 8'h00);
        dat_w(8'h01);
        cmd_w(8'h68);
        chk("R5 special mask lets 6 in", ack_vector, 8'h26);
        cmd_w(8'h48);
        chk("R5 special mask off blocks", {7'd0, irq_out}, 8'h00);
        dat_w(8'h00);
        cmd_w(8'h68);
        chk("R5 zero mask no effect", {7'd0, irq_out}, 8'h00);
        cmd_w(8'h48);
        cmd_w(8'h65);
        chk("R9 specific clear 5 frees 6", ack_vector, 8'h26);
        do_ack(v);
        cmd_w(8'h20);
        set_lines(8'h00);
    endtask

    task automatic t_rotate;
        set_lines(8'h20);
        do_ack(v);
        set_lines(8'h24);
        do_ack(v); chk("R4 nested ack level 2", v, 8'h22);
        cmd_w(8'hA0);
        bus_read(1'b0, v); chk("R8 rotating clear leaves 5", v, 8'h20);
        set_lines(8'h00);
        set_lines(8'h12);
        chk("R8 rotated order picks 4", ack_vector, 8'h24);
        cmd_w(8'hE5);
        bus_read(1'b0, v); chk("R9 rotate-specific clears 5", v, 8'h00);
        chk("R9 lowest=5 picks 1", ack_vector, 8'h21);
        set_lines(8'h00);
        do_ack(v);
        chk("R4 in-service 1 blocks 4", {7'd0, irq_out}, 8'h00);
        cmd_w(8'h20);
        do_ack(v); chk("R8 then level 4", v, 8'h24);
        cmd_w(8'h20);
        cmd_w(8'hC7);
    endtask

    task automatic t_auto_end;
        init_seq(8'h80, 1'b1);
        set_lines(8'h08);
        do_ack(v); chk("R7 auto-end vector", v, 8'h83);
        cmd_w(8'h0B);
        bus_read(1'b0, v); chk("R7 in-service stays clear", v, 8'h00);
        cmd_w(8'h80);
        set_lines(8'h00);
        set_lines(8'h48);
        do_ack(v); chk("R7 first of 3 and 6", v, 8'h83);
        set_lines(8'h00);
        set_lines(8'h08);
        chk("R7 rotation makes 6 win", ack_vector, 8'h86);
        cmd_w(8'h00);
        do_ack(v); chk("R7 rotate off ack 6", v, 8'h86);
        chk("R7 no rotation keeps 3 last", ack_vector, 8'h83);
        do_ack(v);
        chk("R6 spurious vector", ack_vector, 8'h87);
        set_lines(8'h00);
    endtask

    task automatic t_poll;
        init_seq(8'h80, 1'b0);
        set_lines(8'h40);
        cmd_w(8'h0C);
        bus_read(1'b0, v); chk("R11 poll returns level 6", v, 8'h86);
        cmd_w(8'h0B);
        bus_read(1'b0, v); chk("R11 poll marks service", v, 8'h40);
        cmd_w(8'h0A);
        cmd_w(8'h0C);
        bus_read(1'b0, v); chk("R11 empty poll", v, 8'h00);
        set_lines(8'h60);
        bus_read(1'b0, v); chk("R11 poll disarmed", v, 8'h20);
        cmd_w(8'h20);
        set_lines(8'h00);
    endtask

    task automatic t_trigger;
        init_seq(8'h10, 1'b0);
        @(negedge clk); trig_wr = 1'b1; trig_wdata = 8'h01;
        @(negedge clk); trig_wr = 1'b0;
        set_lines(8'h01);
        bus_read(1'b0, v); chk("R12 level line pending", v, 8'h01);
        do_ack(v); chk("R12 level vector", v, 8'h10);
        bus_read(1'b0, v); chk("R12 level re-pends", v, 8'h01);
        set_lines(8'h00);
        bus_read(1'b0, v); chk("R12 level follows line", v, 8'h00);
        cmd_w(8'h20);
        set_lines(8'h80);
        do_ack(v); chk("R12 edge vector", v, 8'h17);
        bus_read(1'b0, v); chk("R12 edge held high no re-pend", v, 8'h00);
        cmd_w(8'h20);
        set_lines(8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_init;
        t_priority;
        t_smm;
        t_rotate;
        t_auto_end;
        t_poll;
        t_trigger;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule